// File: doc/BRIEF.md
# Minimal adaptive mesh route selector

This unit computes the output direction for one packet at one router of a two-dimensional mesh. Each router has four neighbour links (east, west, north, south) and a local ejection port. From the router's own coordinates and the packet's destination coordinates, the unit finds the productive directions. These are the directions that shorten the remaining X or Y distance, so the packet stays inside the minimal rectangle between the current node and the destination.

In adaptive mode the unit removes candidates that would make a turn forbidden by an odd-even column rule. It then prefers directions that are neither congested nor failed, and breaks ties with a fixed X-before-Y priority. In dimension-order mode it always finishes the X distance before moving in Y. The chosen port goes into a one-entry output register with a valid/ready handshake. Congestion and fault information arrive as bit vectors from outside.

Top module: `mesh_route_sel`

## Requirements
- R1: When the destination equals the current node, the port is LOCAL (code 0) and blocked is 0.
- R2: Port codes are LOCAL=0, EAST=1 (+x), WEST=2 (-x), NORTH=3 (+y), SOUTH=4 (-y). Away from the destination, the chosen port is always a productive direction.
- R3: With dor_mode=1, an EAST or WEST move is chosen while the X coordinates differ, and NORTH or SOUTH only after they match. The masks do not change this choice. Blocked is 1 exactly when the chosen direction is flagged in either mask.
- R4: In adaptive mode, a direction flagged in cong_mask or fail_mask is not chosen while another legal candidate is unflagged. Mask bits are bit0 EAST, bit1 WEST, bit2 NORTH, bit3 SOUTH.
- R5: Among unflagged legal candidates, the priority order is EAST, WEST, NORTH, SOUTH.
- R6: The arrival direction in_dir uses the port codes, with 0 meaning locally injected. A packet travelling EAST may not turn NORTH or SOUTH in an even column (cur_x even). A packet travelling NORTH or SOUTH may not turn WEST in an odd column.
- R7: If the turn rule would remove every productive direction, the rule is waived for that packet.
- R8: If every legal candidate is flagged, the highest-priority legal candidate is chosen and blocked is 1. Otherwise, in adaptive mode, blocked is 0.
- R9: The output is registered, with in_ready = !out_valid || out_ready. An accepted request appears one cycle later. While out_valid=1 and out_ready=0, the outputs hold.
- R10: After reset, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| cur_x | input | CW | Router X coordinate |
| cur_y | input | CW | Router Y coordinate |
| dst_x | input | CW | Destination X coordinate |
| dst_y | input | CW | Destination Y coordinate |
| in_dir | input | 3 | Direction the packet was travelling on arrival (0 = injected) |
| dor_mode | input | 1 | 1 = dimension-order routing |
| cong_mask | input | 4 | Congested outputs (E,W,N,S in bits 0..3) |
| fail_mask | input | 4 | Failed outputs (E,W,N,S in bits 0..3) |
| out_valid | output | 1 | Registered selection valid |
| out_ready | input | 1 | Consumer takes selection |
| out_port | output | 3 | Chosen port code |
| out_blocked | output | 1 | Chosen port is flagged |

## Verification
A wrong comparator or turn filter shows up as an out_port that is unproductive or takes a forbidden turn. It appears at the first vector that reaches that coordinate and arrival combination, one cycle after acceptance. A wrong priority or mask handling shows up as a different legal port, or a wrong blocked flag, on the matching mask pattern. A faulty holding register shows up as changed outputs or an asserted in_ready during the backpressure window.

// File: rtl/mrs_pkg.sv
// Shared port codes and mask bit positions for the mesh route selector.
package mrs_pkg;
    localparam int NDIR = 4;                 // neighbour directions
    localparam int PW   = 3;                 // port code width
    localparam logic [PW-1:0] P_LOCAL = 3'd0;
    localparam logic [PW-1:0] P_EAST  = 3'd1;
    localparam logic [PW-1:0] P_WEST  = 3'd2;
    localparam logic [PW-1:0] P_NORTH = 3'd3;
    localparam logic [PW-1:0] P_SOUTH = 3'd4;
    // mask bit index i corresponds to port code i+1
    localparam int B_E = 0;
    localparam int B_W = 1;
    localparam int B_N = 2;
    localparam int B_S = 3;
endpackage

// File: rtl/mrs_productive.sv
// Productive direction finder.
// Compares current and destination coordinates per dimension and flags the
// directions that shorten the remaining distance. Assumes unsigned coordinates.
module mrs_productive #(
    parameter int CW = 4
) (
    input  logic [CW-1:0]           cur_x,
    input  logic [CW-1:0]           cur_y,
    input  logic [CW-1:0]           dst_x,
    input  logic [CW-1:0]           dst_y,
    output logic [mrs_pkg::NDIR-1:0] prod,
    output logic                    at_dest
);
    logic [CW-1:0] cur_c [2];
    logic [CW-1:0] dst_c [2];
    logic [1:0]    same;

    assign cur_c[0] = cur_x;
    assign cur_c[1] = cur_y;
    assign dst_c[0] = dst_x;
    assign dst_c[1] = dst_y;

    // one comparator pair per dimension: bit 2d = increase, bit 2d+1 = decrease
    for (genvar d = 0; d < 2; d++) begin : g_dim
        assign prod[2*d]   = dst_c[d] > cur_c[d];
        assign prod[2*d+1] = dst_c[d] < cur_c[d];
        assign same[d]     = dst_c[d] == cur_c[d];
    end

    assign at_dest = &same;
endmodule

// File: rtl/mrs_turn_filter.sv
// Odd-even turn filter.
// Removes productive directions whose turn is forbidden in the current column;
// waives the rule when it would leave no productive direction.
module mrs_turn_filter
    import mrs_pkg::*;
(
    input  logic            x_odd,
    input  logic [PW-1:0]   in_dir,
    input  logic [NDIR-1:0] prod,
    output logic [NDIR-1:0] legal
);
    logic [NDIR-1:0] forbid;
    logic [NDIR-1:0] kept;

    // build the forbidden-turn set from the arrival direction and column parity
    always_comb begin
        forbid = '0;
        if (in_dir == P_EAST && !x_odd) begin
            forbid[B_N] = 1'b1;
            forbid[B_S] = 1'b1;
        end
        if ((in_dir == P_NORTH || in_dir == P_SOUTH) && x_odd)
            forbid[B_W] = 1'b1;
    end

    assign kept  = prod & ~forbid;
    assign legal = (kept != '0) ? kept : prod;

    // R6
    legal_subset_chk: assert final ((legal & ~prod) == '0);
endmodule

// File: rtl/mrs_pick.sv
// Port picker.
// Adaptive mode: first unflagged legal candidate in E,W,N,S order, else first
// legal candidate with blocked set. Dimension-order mode: X before Y.
module mrs_pick
    import mrs_pkg::*;
(
    input  logic            dor_mode,
    input  logic            at_dest,
    input  logic [NDIR-1:0] prod,
    input  logic [NDIR-1:0] legal,
    input  logic [NDIR-1:0] bad,
    output logic [PW-1:0]   port,
    output logic            blocked
);
    logic [NDIR-1:0] dor_cand;
    logic [NDIR-1:0] avail;
    logic [NDIR-1:0] cand;
    logic [NDIR-1:0] onehot;

    assign dor_cand = (prod[B_W:B_E] != 2'b00) ? {2'b00, prod[B_W:B_E]} : prod;
    assign avail    = legal & ~bad;
    assign cand     = dor_mode ? dor_cand : ((avail != '0) ? avail : legal);

    // lowest set bit of the candidate set wins
    always_comb begin
        onehot = '0;
        port   = P_LOCAL;
        for (int i = NDIR - 1; i >= 0; i--) begin
            if (cand[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                port      = PW'(i + 1);
            end
        end
        if (at_dest) begin
            onehot = '0;
            port   = P_LOCAL;
        end
    end

    assign blocked = |(onehot & bad);

    // R2
    pick_onehot_chk: assert final ($onehot0(onehot));
    // R4
    avoid_bad_chk: assert final (dor_mode || at_dest || avail == '0 || (onehot & bad) == '0);
endmodule

// File: rtl/mesh_route_sel.sv
// Minimal adaptive mesh route selector, top level.
// Computes the next output port for a packet and holds it in a one-entry
// register with valid/ready flow control. Assumes masks are stable while
// in_valid is high and accepted in the same cycle.
module mesh_route_sel
    import mrs_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [CW-1:0]   cur_x,
    input  logic [CW-1:0]   cur_y,
    input  logic [CW-1:0]   dst_x,
    input  logic [CW-1:0]   dst_y,
    input  logic [2:0]      in_dir,
    input  logic            dor_mode,
    input  logic [3:0]      cong_mask,
    input  logic [3:0]      fail_mask,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [2:0]      out_port,
    output logic            out_blocked
);
    logic [NDIR-1:0] prod;
    logic [NDIR-1:0] legal;
    logic            at_dest;
    logic [PW-1:0]   nxt_port;
    logic            nxt_blocked;

    mrs_productive #(.CW(CW)) u_prod (
        .cur_x  (cur_x),
        .cur_y  (cur_y),
        .dst_x  (dst_x),
        .dst_y  (dst_y),
        .prod   (prod),
        .at_dest(at_dest)
    );

    mrs_turn_filter u_turn (
        .x_odd (cur_x[0]),
        .in_dir(in_dir),
        .prod  (prod),
        .legal (legal)
    );

    mrs_pick u_pick (
        .dor_mode(dor_mode),
        .at_dest (at_dest),
        .prod    (prod),
        .legal   (legal),
        .bad     (cong_mask | fail_mask),
        .port    (nxt_port),
        .blocked (nxt_blocked)
    );

    assign in_ready = !out_valid || out_ready;

    // output register: load on accept, drop valid when consumed without refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_port    <= P_LOCAL;
            out_blocked <= 1'b0;
        end else if (in_valid && in_ready) begin
            out_valid   <= 1'b1;
            out_port    <= nxt_port;
            out_blocked <= nxt_blocked;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_blocked)));
    // R9
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    // R1
    local_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port == P_LOCAL) |-> !out_blocked);
    // R2
    port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_port <= P_SOUTH));
endmodule

// File: tb/tb_mesh_route_sel.sv
// Sweep bench: all coordinate pairs on a 4x4 patch, all arrival directions,
// all mask patterns, both modes; plus reset and backpressure checks.
module tb_mesh_route_sel;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready, dor_mode, out_valid, out_ready, out_blocked;
    logic [CW-1:0] cur_x, cur_y, dst_x, dst_y;
    logic [2:0]    in_dir, out_port;
    logic [3:0]    cong_mask, fail_mask;
    int            n_chk = 0;
    int            n_bad = 0;
    int            unprod = 0;

    always #2.5 clk = ~clk;

    mesh_route_sel #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .in_dir(in_dir), .dor_mode(dor_mode), .cong_mask(cong_mask),
        .fail_mask(fail_mask), .out_valid(out_valid), .out_ready(out_ready),
        .out_port(out_port), .out_blocked(out_blocked)
    );

    // expected {blocked, port[2:0]} and the requirement that governs it
    function automatic logic [3:0] ref_sel(input int cx, cy, dx, dy, dir,
                                           input bit dor, input logic [3:0] bad,
                                           output string tag);
        logic [3:0] pr, fb, kept, lg, av, cd;
        logic [2:0] p;
        pr = {dy < cy, dy > cy, dx < cx, dx > cx};
        fb = 4'b0000;
        if (dir == 1 && cx % 2 == 0) fb = 4'b1100;
        if ((dir == 3 || dir == 4) && cx % 2 == 1) fb = 4'b0010;
        kept = pr & ~fb;
        lg = (kept != 0) ? kept : pr;
        av = lg & ~bad;
        if (dx == cx && dy == cy) begin tag = "R1"; return 4'b0000; end
        if (dor) cd = (pr[1:0] != 0) ? {2'b00, pr[1:0]} : pr;
        else     cd = (av != 0) ? av : lg;
        p = 0;
        for (int i = 3; i >= 0; i--) if (cd[i]) p = 3'(i + 1);
        if (dor)                   tag = "R3";
        else if (av == 0)          tag = "R8";
        else if (kept == 0)        tag = "R7";
        else if ((pr & fb) != 0)   tag = "R6";
        else if (bad != 0)         tag = "R4";
        else                       tag = "R5";
        return {bad[p-1], p};
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, result checked at the following negedge
    task automatic run_vec(input int cx, cy, dx, dy, dir, input bit dor, input logic [3:0] m);
        string tag;
        logic [3:0] e;
        cur_x = CW'(cx); cur_y = CW'(cy); dst_x = CW'(dx); dst_y = CW'(dy);
        in_dir = 3'(dir); dor_mode = dor;
        cong_mask = m & 4'b0101; fail_mask = m & 4'b1010;
        in_valid = 1'b1; out_ready = 1'b1;
        e = ref_sel(cx, cy, dx, dy, dir, dor, m, tag);
        @(negedge clk);
        check(tag, {out_blocked, out_port}, e);
        if (!(dx == cx && dy == cy)) begin
            if (!((out_port == 1 && dx > cx) || (out_port == 2 && dx < cx) ||
                  (out_port == 3 && dy > cy) || (out_port == 4 && dy < cy)))
                unprod++;
        end
    endtask

    initial begin
        #900000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; dor_mode = 1'b0;
        cur_x = '0; cur_y = '0; dst_x = '0; dst_y = '0; in_dir = '0;
        cong_mask = '0; fail_mask = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {3'b000, out_valid}, 4'h0);
        rst_n = 1'b1;

        for (int cx = 0; cx < 4; cx++)
            for (int cy = 0; cy < 4; cy++)
                for (int dx = 0; dx < 4; dx++)
                    for (int dy = 0; dy < 4; dy++)
                        for (int dir = 0; dir < 5; dir++) begin
                            for (int m = 0; m < 16; m++)
                                run_vec(cx, cy, dx, dy, dir, 1'b0, 4'(m));
                            run_vec(cx, cy, dx, dy, dir, 1'b1, 4'b0000);
                            run_vec(cx, cy, dx, dy, dir, 1'b1, 4'b1111);
                        end
        // R2: every non-local output was productive
        check("R2", 4'(unprod), 4'h0);
        // R9: valid stays high after a streamed vector
        check("R9", {3'b000, out_valid}, 4'h1);

        // R9 backpressure: load WEST, then stall with a different request
        run_vec(2, 1, 0, 1, 0, 1'b0, 4'b0000);
        out_ready = 1'b0;
        dst_x = 4'd3;
        #1;
        check("R9", {3'b000, in_ready}, 4'h0);
        @(negedge clk);
        check("R9", {out_valid, out_port}, 4'b1010);
        @(negedge clk);
        check("R9", {out_valid, out_port}, 4'b1010);
        out_ready = 1'b1; in_valid = 1'b0;
        #1;
        check("R9", {3'b000, in_ready}, 4'h1);
        @(negedge clk);
        check("R9", {3'b000, out_valid}, 4'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule